// File: doc/BRIEF.md
# Write-Conflict Deadlock Lock Tracker

The block watches a group of cores that issue write requests to a shared set of cache cells in lockstep. On every step pulse each core presents one request field. The field holds either a no-operation code or the number of the cell that the core writes. No arbitration exists. When two or more live cores aim at the same live cell in one step, every one of those cores and that cell freeze for good. A live core that later aims at a frozen cell freezes in the step where it does so. A frozen core's later requests have no effect.

The tracker keeps one lock flag for each core and one for each cell. For each core it also stores the number of the step in which that core froze. It is used to study how deadlocks spread through a request schedule. The data held in the cells, any arbitration and any recovery are not part of this block. All state is registered and changes only on a clock edge where `step_valid` is high.

Top module: `deadlock_tracker`

## Requirements
- R1: After a synchronous reset, every core lock flag, every cell lock flag and every recorded step number is 0.
- R2: If two or more unlocked cores request the same unlocked cell in one step, all of them and that cell become locked. Each of those cores records the current step number. Core i's request sits at `req_flat[i*IDX_W +: IDX_W]`. Cell c (1-based) is `cell_locked[c-1]`. Core i's step is `lock_step_flat[i*STEP_W +: STEP_W]`.
- R3: An unlocked core that requests a cell locked in an earlier step becomes locked in the current step. A cell that collides in the current step counts as locked only from the next step.
- R4: A locked core's requests are ignored. They do not count toward a collision, and they do not change that core's recorded step.
- R5: A request of 0, a request above the cell count (K), or a lone request to an unlocked cell locks nothing.
- R6: Steps are numbered from 1, and each clock edge with `step_valid` high is one step, whether or not anything locks. With `step_valid` low, requests are ignored and the step count does not advance.
- R7: The step counter saturates at 2^STEP_W-1 (127 by default) instead of wrapping. Later locks record that value.
- R8: Lock flags never clear except on reset. A core's recorded step number never changes after it is locked.
- R9: A core that has never been locked reports step number 0. A locked core reports a nonzero step number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | Applies the requests as one step |
| req_flat | input | N_CORES*IDX_W | Per-core request: 0 = idle, 1..N_CELLS = target cell |
| core_locked | output | N_CORES | Core lock flags |
| cell_locked | output | N_CELLS | Cell lock flags, bit c-1 = cell c |
| lock_step_flat | output | N_CORES*STEP_W | Per-core step of locking, 0 = never |

## Verification
Pair collisions, a three-way collision and lone requests to the same kind of target are compared, which separates "shared target" from "any write". Requests to a cell locked in an earlier step, and requests from cores that are already locked, show whether old locks and live cores are weighted correctly. Idle codes, codes above the cell count and requests held while `step_valid` is low must all leave the state untouched. A long run of empty steps shows that step numbering counts every pulse and stops at saturation.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int DEF_CORES = 100;
  localparam int DEF_CELLS = 100;
  localparam int DEF_STEPS = 100;
endpackage

// File: rtl/lt_req_decode.sv
module lt_req_decode #(
  parameter int N_CELLS = 100,
  parameter int IDX_W   = 7
) (
  input  logic [IDX_W-1:0]   req,
  input  logic               core_is_locked,
  input  logic [N_CELLS-1:0] cell_is_locked,
  input  logic [N_CELLS-1:0] collide,
  output logic [N_CELLS-1:0] claim,
  output logic               lock_now
);
  logic active;
  logic hit_old;

  always_comb begin
    active = !core_is_locked && (req != '0) && (req <= IDX_W'(N_CELLS));
    claim   = '0;
    hit_old = 1'b0;
    for (int j = 0; j < N_CELLS; j++) begin
      if (active && (req == IDX_W'(j + 1))) begin
        if (cell_is_locked[j]) hit_old = 1'b1;
        else claim[j] = 1'b1;
      end
    end
    lock_now = hit_old || (|(claim & collide));
  end
endmodule

// File: rtl/lt_collide.sv
module lt_collide #(
  parameter int N_CORES = 100,
  parameter int N_CELLS = 100
) (
  input  logic [N_CORES*N_CELLS-1:0] claims_flat,
  output logic [N_CELLS-1:0]         collide
);
  logic [N_CELLS-1:0] seen;

  always_comb begin
    seen    = '0;
    collide = '0;
    for (int i = 0; i < N_CORES; i++) begin
      collide = collide | (seen & claims_flat[i*N_CELLS +: N_CELLS]);
      seen    = seen | claims_flat[i*N_CELLS +: N_CELLS];
    end
  end
endmodule

// File: rtl/lt_step_ctr.sv
module lt_step_ctr #(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [STEP_W-1:0] step_cur
);
  localparam logic [STEP_W-1:0] STEP_TOP = '1;
  logic [STEP_W-1:0] done_cnt;

  always_comb step_cur = (done_cnt == STEP_TOP) ? STEP_TOP : done_cnt + STEP_W'(1);

  always_ff @(posedge clk) begin
    if (rst) done_cnt <= '0;
    else if (adv) done_cnt <= step_cur;
  end

  assert_step_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && done_cnt == STEP_TOP) |=> (done_cnt == STEP_TOP));
  assert_step_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(done_cnt));
endmodule

// File: rtl/lt_lock_regs.sv
module lt_lock_regs #(
  parameter int N_CORES = 100,
  parameter int N_CELLS = 100,
  parameter int STEP_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      adv,
  input  logic [N_CORES-1:0]        core_set,
  input  logic [N_CELLS-1:0]        cell_set,
  input  logic [STEP_W-1:0]         step_cur,
  output logic [N_CORES-1:0]        core_locked,
  output logic [N_CELLS-1:0]        cell_locked,
  output logic [N_CORES*STEP_W-1:0] lock_step_flat
);
  logic [STEP_W-1:0] lock_step [N_CORES];

  always_ff @(posedge clk) begin
    if (rst) begin
      core_locked <= '0;
      cell_locked <= '0;
      for (int i = 0; i < N_CORES; i++) lock_step[i] <= '0;
    end else if (adv) begin
      core_locked <= core_locked | core_set;
      cell_locked <= cell_locked | cell_set;
      for (int i = 0; i < N_CORES; i++)
        if (core_set[i]) lock_step[i] <= step_cur;
    end
  end

  for (genvar g = 0; g < N_CORES; g++) begin : g_step_out
    assign lock_step_flat[g*STEP_W +: STEP_W] = lock_step[g];

    assert_step_kept_R8: assert property (@(posedge clk) disable iff (rst)
      core_locked[g] |=> $stable(lock_step[g]));
    assert_step_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
      core_locked[g] |-> (lock_step[g] != '0));
  end

  assert_core_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(core_locked) & ~core_locked) == '0));
  assert_cell_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(cell_locked) & ~cell_locked) == '0));
endmodule

// File: rtl/deadlock_tracker.sv
module deadlock_tracker
  import lt_pkg::*;
#(
  parameter int N_CORES   = DEF_CORES,
  parameter int N_CELLS   = DEF_CELLS,
  parameter int MAX_STEPS = DEF_STEPS,
  localparam int IDX_W    = $clog2(N_CELLS + 1),
  localparam int STEP_W   = $clog2(MAX_STEPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step_valid,
  input  logic [N_CORES*IDX_W-1:0]  req_flat,
  output logic [N_CORES-1:0]        core_locked,
  output logic [N_CELLS-1:0]        cell_locked,
  output logic [N_CORES*STEP_W-1:0] lock_step_flat
);
  logic [N_CORES*N_CELLS-1:0] claims_flat;
  logic [N_CELLS-1:0]         collide;
  logic [N_CORES-1:0]         core_set;
  logic [STEP_W-1:0]          step_cur;

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    lt_req_decode #(.N_CELLS(N_CELLS), .IDX_W(IDX_W)) i_dec (
      .req           (req_flat[g*IDX_W +: IDX_W]),
      .core_is_locked(core_locked[g]),
      .cell_is_locked(cell_locked),
      .collide       (collide),
      .claim         (claims_flat[g*N_CELLS +: N_CELLS]),
      .lock_now      (core_set[g])
    );
  end

  lt_collide #(.N_CORES(N_CORES), .N_CELLS(N_CELLS)) i_collide (
    .claims_flat(claims_flat),
    .collide    (collide)
  );

  lt_step_ctr #(.STEP_W(STEP_W)) i_step (
    .clk     (clk),
    .rst     (rst),
    .adv     (step_valid),
    .step_cur(step_cur)
  );

  lt_lock_regs #(.N_CORES(N_CORES), .N_CELLS(N_CELLS), .STEP_W(STEP_W)) i_regs (
    .clk           (clk),
    .rst           (rst),
    .adv           (step_valid),
    .core_set      (core_set),
    .cell_set      (collide),
    .step_cur      (step_cur),
    .core_locked   (core_locked),
    .cell_locked   (cell_locked),
    .lock_step_flat(lock_step_flat)
  );

  assert_collide_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (step_valid && (|collide)) |-> ($countones(core_set) >= 2));
  assert_locked_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    ((core_set & core_locked) == '0));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> ($stable(core_locked) && $stable(cell_locked) && $stable(lock_step_flat)));
endmodule

// File: tb/test_deadlock_tracker.sv
module test_deadlock_tracker;
  localparam int NC = 100;
  localparam int NK = 100;
  localparam int IW = 7;
  localparam int SW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_valid = 1'b0;
  logic [IW-1:0] req [NC];
  logic [NC*IW-1:0] req_flat;
  logic [NC-1:0] core_locked;
  logic [NK-1:0] cell_locked;
  logic [NC*SW-1:0] lock_step_flat;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NC; i++) req_flat[i*IW +: IW] = req[i];

  deadlock_tracker i_deadlock_tracker (
    .clk(clk), .rst(rst), .step_valid(step_valid), .req_flat(req_flat),
    .core_locked(core_locked), .cell_locked(cell_locked),
    .lock_step_flat(lock_step_flat)
  );

  task automatic clear_reqs();
    for (int i = 0; i < NC; i++) req[i] = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step_valid = 1'b0; clear_reqs();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_step();
    step_valid = 1'b1;
    @(negedge clk);
    step_valid = 1'b0;
    clear_reqs();
  endtask

  task automatic check_core(int c, bit exp_lk, int exp_st, string tag);
    int act_st;
    act_st = int'(lock_step_flat[c*SW +: SW]);
    checks++;
    if (core_locked[c] !== exp_lk || act_st != exp_st) begin
      failures++;
      $display("FAIL %s core %0d: locked=%0b step=%0d expected locked=%0b step=%0d",
               tag, c, core_locked[c], act_st, exp_lk, exp_st);
    end
  endtask

  task automatic check_cell(int k, bit exp_lk, string tag);
    checks++;
    if (cell_locked[k-1] !== exp_lk) begin
      failures++;
      $display("FAIL %s cell %0d: locked=%0b expected %0b", tag, k, cell_locked[k-1], exp_lk);
    end
  endtask

  task automatic check_counts(int exp_cores, int exp_cells, string tag);
    checks++;
    if ($countones(core_locked) != exp_cores || $countones(cell_locked) != exp_cells) begin
      failures++;
      $display("FAIL %s: locked cores=%0d cells=%0d expected %0d/%0d", tag,
               $countones(core_locked), $countones(cell_locked), exp_cores, exp_cells);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check_counts(0, 0, "R1");
    checks++;
    if (lock_step_flat !== '0) begin
      failures++;
      $display("FAIL R1 steps: act=%0h exp=0", lock_step_flat);
    end
    check_core(5, 0, 0, "R9");
  endtask

  task automatic t_basic();
    do_reset();
    req[0] = 1; req[1] = 1; req[2] = 2; req[3] = 3;
    do_step();
    check_core(0, 1, 1, "R2");
    check_core(1, 1, 1, "R2");
    check_core(2, 0, 0, "R5");
    check_cell(1, 1, "R2");
    check_cell(2, 0, "R5");
    req[1] = 2; req[2] = 3; req[3] = 2;
    do_step();
    check_counts(2, 1, "R4");
    check_core(1, 1, 1, "R8");
    req[2] = 1;
    do_step();
    check_core(2, 1, 3, "R3");
    check_core(3, 0, 0, "R9");
    check_counts(3, 1, "R3");
  endtask

  task automatic t_ignore_locked();
    do_reset();
    req[0] = 5; req[1] = 5;
    do_step();
    req[0] = 7; req[2] = 7;
    do_step();
    check_core(2, 0, 0, "R4");
    check_cell(7, 0, "R4");
    check_core(0, 1, 1, "R4");
  endtask

  task automatic t_multi_and_range();
    do_reset();
    req[10] = 50; req[11] = 50; req[12] = 50;
    req[20] = 101; req[21] = 101; req[30] = 100;
    do_step();
    check_core(12, 1, 1, "R2");
    check_cell(50, 1, "R2");
    check_core(20, 0, 0, "R5");
    check_core(30, 0, 0, "R5");
    check_counts(3, 1, "R5");
    req[30] = 100; req[31] = 100;
    do_step();
    check_core(31, 1, 2, "R2");
    check_cell(100, 1, "R2");
  endtask

  task automatic t_idle_hold();
    do_reset();
    for (int s = 0; s < 3; s++) do_step();
    req[0] = 4; req[1] = 4;
    repeat (4) @(negedge clk);
    check_counts(0, 0, "R6");
    do_step();
    check_core(0, 1, 4, "R6");
    check_core(1, 1, 4, "R6");
  endtask

  task automatic t_saturate();
    do_reset();
    for (int s = 0; s < 130; s++) do_step();
    req[40] = 9; req[41] = 9;
    do_step();
    check_core(40, 1, 127, "R7");
    req[42] = 9;
    do_step();
    check_core(42, 1, 127, "R7");
  endtask

  initial begin
    clear_reqs();
    t_reset();
    t_basic();
    t_ignore_locked();
    t_multi_and_range();
    t_idle_hold();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule